// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

The core fetches, decodes and retires one 32-bit instruction on every clock edge. It covers a small load/store integer subset: register-register add, subtract, bitwise and, bitwise or and signed set-less-than; add-immediate; word load and word store; branch-if-equal; and an absolute jump inside the current 256 MB region. The program counter, a 32-entry register file, an immediate extender, the ALU with its zero flag, and word-addressed instruction and data memories all sit inside the block.

Decoding happens in two stages. A main decoder turns the opcode into datapath controls plus a two-bit ALU class. A second decoder turns that class, together with the function field of register-register instructions, into the exact ALU operation. Software loads the instruction memory through hierarchical access before reset is released. The only outputs are debug views of the current PC and of the register write that commits at the next edge.

Top module: `scp_core`

## Requirements
- R1: While rst_ni is low the PC is 0 at once, without waiting for a clock edge. The first instruction after release is fetched from byte address 0.
- R2: Opcode 0x00 is register-register. Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. Function 0x20 adds, 0x22 subtracts rt from rs, 0x24 ands, 0x25 ors, and 0x2A writes 1 when rs < rt as signed values and 0 otherwise. The result goes to rd.
- R3: Opcode 0x08 writes rs plus the sign-extended immediate in bits [15:0] to rt.
- R4: Opcode 0x2B stores rt to data memory at rs plus the sign-extended immediate, with no register write. Opcode 0x23 loads rt from that address. Both memories use byte-address bits [N+1:2] as the word index.
- R5: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, and nothing is written.
- R6: An unequal branch, and every instruction that is neither a taken branch nor a jump, moves the PC on by 4.
- R7: Opcode 0x02 loads the PC with PC+4 bits [31:28], then instruction bits [25:0], then two zero bits. It writes nothing.
- R8: Register 0 always reads as zero. A write aimed at register 0 is dropped and is not shown on the debug write port.
- R9: An opcode outside the set above writes neither registers nor memory, and the PC moves on by 4.
- R10: An instruction whose destination is also one of its sources reads the old value. The new value is visible to the next instruction.
- R11: pc_o is the PC of the instruction executing now. rf_we_o, rf_waddr_o and rf_wdata_o show the register write that this instruction commits at the coming rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the PC |
| pc_o | output | 32 | Byte address of the current instruction |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |

## Verification
Two functions meet in one cycle when an instruction both reads and writes the same register. The sequence `add r1,r1,r1` followed by `add r15,r1,r0` provokes this. The first must report the doubled old value, and the second must see the new one. A store followed at once by a load of the same word, and a taken branch landing next to skipped filler words, check the memory write timing and the PC selection. Each instruction in the sequence is judged at the debug ports halfway through its cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic     reg_dst;
    logic     reg_write;
    logic     alu_src;
    logic     mem_write;
    logic     mem_read;
    logic     mem_to_reg;
    logic     branch;
    logic     jump;
    logic     sign_ext;
    alu_cls_e alu_cls;
  } ctrl_t;
endpackage

// File: rtl/scp_main_ctrl.sv
module scp_main_ctrl
  import scp_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o          = '0;          // unknown opcode: no writes, sequential PC
    ctrl_o.sign_ext = 1'b1;
    ctrl_o.alu_cls  = CLS_ADD;
    unique case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_cls   = CLS_FUNCT;
      end
      OPC_ADDI: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
      end
      OPC_LW: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_read   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_cls = CLS_SUB;
      end
      OPC_J: ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scp_alu_ctrl.sv
module scp_alu_ctrl
  import scp_pkg::*;
(
  input  alu_cls_e   cls_i,
  input  logic [5:0] funct_i,
  output alu_op_e    op_o
);
  always_comb begin
    op_o = ALU_ADD;
    case (cls_i)
      CLS_SUB: op_o = ALU_SUB;
      CLS_FUNCT: begin
        case (funct_i)
          FN_SUB:  op_o = ALU_SUB;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_SLT:  op_o = ALU_SLT;
          default: op_o = ALU_ADD;
        endcase
      end
      default: op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = a_i + b_i;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && wa_i != '0) regs_q[wa_i] <= wd_i;
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];

  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o
);
  localparam int IA = $clog2(IMEM_WORDS);
  localparam int DA = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  initial for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_res, mem_rdata;
  logic            alu_zero, branch_taken;
  logic [4:0]      waddr;
  ctrl_t           ctrl;
  alu_op_e         alu_op;

  assign instr = imem_q[pc_q[IA+1:2]];

  scp_main_ctrl u_main_ctrl (.opcode_i(instr[31:26]), .ctrl_o(ctrl));

  scp_alu_ctrl u_alu_ctrl (
    .cls_i(ctrl.alu_cls), .funct_i(instr[5:0]), .op_o(alu_op)
  );

  scp_regfile #(.W(XLEN), .NREG(NREG)) u_regfile (
    .clk_i, .rst_ni,
    .ra_a_i(instr[25:21]), .ra_b_i(instr[20:16]),
    .rd_a_o(rs_data),      .rd_b_o(rt_data),
    .we_i(rf_we_o), .wa_i(waddr), .wd_i(rf_wdata_o)
  );

  assign imm_ext = ctrl.sign_ext ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                                 : {{(XLEN-16){1'b0}}, instr[15:0]};
  assign alu_b   = ctrl.alu_src ? imm_ext : rt_data;

  scp_alu #(.W(XLEN)) u_alu (
    .op_i(alu_op), .a_i(rs_data), .b_i(alu_b), .res_o(alu_res), .zero_o(alu_zero)
  );

  always_ff @(posedge clk_i) begin
    if (ctrl.mem_write) dmem_q[alu_res[DA+1:2]] <= rt_data;
  end
  assign mem_rdata = ctrl.mem_read ? dmem_q[alu_res[DA+1:2]] : '0;

  assign waddr      = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign rf_we_o    = ctrl.reg_write && (waddr != 5'd0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = ctrl.mem_to_reg ? mem_rdata : alu_res;

  assign pc_plus4     = pc_q + XLEN'(4);
  assign br_target    = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target   = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign branch_taken = ctrl.branch && alu_zero;

  always_comb begin
    pc_next = pc_plus4;
    if (ctrl.jump)        pc_next = jmp_target;
    else if (branch_taken) pc_next = br_target;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end
  assign pc_o = pc_q;

  logic unused_bits;
  assign unused_bits = ^{pc_q[XLEN-1:IA+2], pc_q[1:0], alu_res[XLEN-1:DA+2],
                         alu_res[1:0], instr[10:6]};

  p_seq_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.jump && !branch_taken) |=> pc_o == $past(pc_q) + 32'd4);
  p_taken_branch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken |=> pc_o == $past(pc_q) + 32'd4 + {$past(imm_ext[XLEN-3:0]), 2'b00});
  p_jump_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> pc_o == {$past(pc_plus4[XLEN-1:XLEN-4]), $past(instr[25:0]), 2'b00});
  p_store_no_regwrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mem_write |-> !rf_we_o);
  p_store_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mem_write |=> dmem_q[$past(alu_res[DA+1:2])] == $past(rt_data));
  p_one_flow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl.mem_write, ctrl.mem_read, ctrl.branch, ctrl.jump}));
endmodule

// File: tb/scp_core_tb_top.sv
module scp_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_o, rf_wdata_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;

  always #4 clk = ~clk;  // 125 MHz

  scp_core dut_i (
    .clk_i(clk), .rst_ni, .pc_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o
  );

  // R2/R3 field layout
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] instr;
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{32'd0,  enc_i(6'h08, 0, 1, 16'd5),        1'b1, 5'd1,  32'd5,        8'd3},  // R3
    '{32'd4,  enc_i(6'h08, 0, 2, 16'hFFFD),     1'b1, 5'd2,  32'hFFFFFFFD, 8'd3},  // R3
    '{32'd8,  enc_r(1, 2, 3, 6'h20),            1'b1, 5'd3,  32'd2,        8'd2},  // R2 add
    '{32'd12, enc_r(1, 2, 4, 6'h22),            1'b1, 5'd4,  32'd8,        8'd2},  // R2 sub
    '{32'd16, enc_r(1, 2, 5, 6'h24),            1'b1, 5'd5,  32'd5,        8'd2},  // R2 and
    '{32'd20, enc_r(1, 2, 6, 6'h25),            1'b1, 5'd6,  32'hFFFFFFFD, 8'd2},  // R2 or
    '{32'd24, enc_r(2, 1, 7, 6'h2A),            1'b1, 5'd7,  32'd1,        8'd2},  // R2 slt true
    '{32'd28, enc_r(1, 2, 8, 6'h2A),            1'b1, 5'd8,  32'd0,        8'd2},  // R2 slt false
    '{32'd32, enc_i(6'h2B, 0, 4, 16'd8),        1'b0, 5'd0,  32'd0,        8'd4},  // R4 store
    '{32'd36, enc_i(6'h23, 0, 9, 16'd8),        1'b1, 5'd9,  32'd8,        8'd4},  // R4 load
    '{32'd40, enc_i(6'h08, 0, 0, 16'd7),        1'b0, 5'd0,  32'd0,        8'd8},  // R8 drop
    '{32'd44, enc_r(0, 0, 10, 6'h20),           1'b1, 5'd10, 32'd0,        8'd8},  // R8 zero
    '{32'd48, enc_i(6'h04, 1, 2, 16'd5),        1'b0, 5'd0,  32'd0,        8'd6},  // R6 not taken
    '{32'd52, enc_i(6'h04, 3, 3, 16'd2),        1'b0, 5'd0,  32'd0,        8'd5},  // R5 taken
    '{32'd64, 32'hFC22_0007,                    1'b0, 5'd0,  32'd0,        8'd9},  // R9 unknown
    '{32'd68, {6'h02, 26'd20},                  1'b0, 5'd0,  32'd0,        8'd7},  // R7 jump
    '{32'd80, enc_i(6'h08, 0, 13, 16'd16),      1'b1, 5'd13, 32'd16,       8'd7},  // R7 landed
    '{32'd84, enc_i(6'h23, 13, 14, 16'hFFF8),   1'b1, 5'd14, 32'd8,        8'd4},  // R4 neg offset
    '{32'd88, enc_r(1, 1, 1, 6'h20),            1'b1, 5'd1,  32'd10,       8'd10}, // R10 old value
    '{32'd92, enc_r(1, 0, 15, 6'h20),           1'b1, 5'd15, 32'd10,       8'd10}, // R10 new value
    '{32'd96, enc_i(6'h04, 0, 0, 16'hFFFF),     1'b0, 5'd0,  32'd0,        8'd5}   // R5 self loop
  };

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input logic ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // R11: port semantics judged for every vector
  task automatic check_vec(input vec_t v);
    check(pc_o == v.pc, v.req, "pc_o (R11)", pc_o, v.pc);
    check(rf_we_o == v.we, v.req, "rf_we_o (R11)", 32'(rf_we_o), 32'(v.we));
    if (v.we) begin
      check(rf_waddr_o == v.waddr, v.req, "rf_waddr_o", 32'(rf_waddr_o), 32'(v.waddr));
      check(rf_wdata_o == v.wdata, v.req, "rf_wdata_o", rf_wdata_o, v.wdata);
    end
  endtask

  initial begin
    #1;
    for (int k = 0; k < NV; k++) dut_i.imem_q[VEC[k].pc[7:2]] = VEC[k].instr;
    for (int k = 0; k < 4; k++) begin  // fillers that must be skipped
      dut_i.imem_q[(k < 2) ? 14 + k : 18 + (k - 2)] = enc_i(6'h08, 0, 11, 16'd99);
    end
    repeat (2) @(negedge clk);
    check(pc_o == 32'd0, 1, "pc in reset", pc_o, 32'd0);  // R1
    rst_ni = 1'b1;
    #1;
    for (int k = 0; k < NV; k++) begin
      check_vec(VEC[k]);
      @(negedge clk);
      #1;
    end
    for (int k = 0; k < 3; k++) begin  // R5 self loop holds
      check(pc_o == 32'd96 && !rf_we_o, 5, "loop pc", pc_o, 32'd96);
      @(negedge clk);
      #1;
    end
    #1 rst_ni = 1'b0;
    #1 check(pc_o == 32'd0, 1, "async reset pc", pc_o, 32'd0);  // R1
    @(negedge clk);
    rst_ni = 1'b1;
    #1 check_vec(VEC[0]);  // R1 restart at 0
    @(negedge clk);
    #1 check_vec(VEC[1]);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule